// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the operand bytes of an indexed instruction, together with the processor's Direct, Data Bank and X/Y index registers, into the effective address of the operand. It supports five indexed modes. Two of them are direct modes: they take the Direct register, add an 8-bit offset and an index, and always land in bank zero. Two are absolute modes: they take a 16-bit operand base, place the Data Bank register above it and add an index. The fifth is absolute long by X: it takes a 24-bit operand base and adds X.

A native-mode flag sets the width of the result. When the flag is set, the full 32-bit index is used and the result is 32 bits wide. When the flag is clear, only the low 16 bits of the index are used and the result is cut to 24 bits.

The request side is a plain valid strobe. The result side is a registered address with a one-cycle valid pulse. The block never stalls: there is no ready signal and no back-pressure. A request is always accepted in the cycle it is presented. The consumer must take `ea_valid` in the cycle it is high. Operand and register inputs only need to be stable in the request cycle.

Top module: `ieag_top`

## Requirements
- R1: Mode code 0 (direct by X) and code 1 (direct by Y) give `ea = (dir_reg + opnd_lo + index) mod 2^16`. The index is `x_reg` for code 0 and `y_reg` for code 1.
- R2: In both direct modes, bits 31:16 of `ea` are zero: the carry out of bit 15 is dropped.
- R3: Mode code 2 (absolute by X) and code 3 (absolute by Y) use a base built as follows: `opnd_lo` on bits 7:0, `opnd_hi` on bits 15:8 and `dbr_reg` on bits 23:16. The selected index is added to this base.
- R4: Mode code 4 (absolute long by X) uses a base built as follows: `opnd_lo` on bits 7:0, `opnd_hi` on bits 15:8 and `opnd_bank` on bits 23:16. `x_reg` is added to this base.
- R5: When `native` is 1, modes 2 to 4 add the full 32-bit index and keep all 32 bits of the sum.
- R6: When `native` is 0, modes 2 to 4 add only the low 16 bits of the index and keep the sum mod 2^24. Bits 31:24 of `ea` are zero.
- R7: A request with a known mode (0 to 4) updates `ea` on the next rising clock edge. In the same edge `ea_valid` goes high, for one cycle per request.
- R8: `ea` holds its value in every cycle without an accepted request.
- R9: Mode codes 5, 6 and 7 give no `ea_valid`. They raise `mode_err` for exactly one cycle and leave `ea` unchanged.
- R10: A synchronous active-high `rst` clears `ea`, `ea_valid` and `mode_err` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per address |
| mode | input | 3 | Addressing mode code (0 to 4 known) |
| native | input | 1 | 1 selects 32-bit results and full index width |
| opnd_lo | input | 8 | First operand byte: direct offset or base low byte |
| opnd_hi | input | 8 | Second operand byte: base high byte |
| opnd_bank | input | 8 | Third operand byte: bank of the long base |
| dir_reg | input | 16 | Direct register |
| dbr_reg | input | 8 | Data Bank register |
| x_reg | input | 32 | X index register |
| y_reg | input | 32 | Y index register |
| ea | output | 32 | Registered effective address |
| ea_valid | output | 1 | One-cycle pulse marking a new `ea` |
| mode_err | output | 1 | One-cycle pulse for an unknown mode code |

## Verification
Every mode code, 0 to 7, is run with `native` both clear and set. Each of these runs is tried with eight operand and register patterns:
- All-zero operands, which exposes stray constant terms.
- Single-bit values, which confirm that each byte lands on its own bit positions.
- Values that carry out of bit 15 in direct mode, which separate the wrap into bank zero from a carry into the bank.
- Values that carry out of bit 23, which separate 24-bit truncation from a 32-bit sum.
- Index values with upper halves set, which show whether the upper index bits are used in only the right cases.

Unknown codes are placed between known requests. This shows that the address is held and that the error pulse is separate from the valid pulse.

// File: rtl/ieag_pkg.sv
package ieag_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIR_X  = 3'd0,
    MODE_DIR_Y  = 3'd1,
    MODE_ABS_X  = 3'd2,
    MODE_ABS_Y  = 3'd3,
    MODE_ABSL_X = 3'd4
  } mode_e;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return (m <= MODE_W'(MODE_ABSL_X));
  endfunction

  function automatic logic mode_direct(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(MODE_DIR_X)) || (m == MODE_W'(MODE_DIR_Y));
  endfunction

  function automatic logic mode_uses_y(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(MODE_DIR_Y)) || (m == MODE_W'(MODE_ABS_Y));
  endfunction

endpackage

// File: rtl/ieag_index_sel.sv
module ieag_index_sel #(
  parameter int ADDR_W = 32,
  parameter int NARROW_W = 16
) (
  input  logic [ADDR_W-1:0] x_i,
  input  logic [ADDR_W-1:0] y_i,
  input  logic              use_y_i,
  input  logic              native_i,
  output logic [ADDR_W-1:0] idx_o
);
  localparam int PAD_W = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0] picked;

  always_comb begin
    picked = use_y_i ? y_i : x_i;
    if (native_i) idx_o = picked;
    else          idx_o = {{PAD_W{1'b0}}, picked[NARROW_W-1:0]};
  end
endmodule

// File: rtl/ieag_base_form.sv
module ieag_base_form
  import ieag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [BYTE_W-1:0]   lo_i,
  input  logic [BYTE_W-1:0]   hi_i,
  input  logic [BYTE_W-1:0]   bank_i,
  input  logic [2*BYTE_W-1:0] dir_i,
  input  logic [BYTE_W-1:0]   dbr_i,
  output logic [ADDR_W-1:0]   base_o
);
  localparam int DIR_W = 2 * BYTE_W;
  localparam int LONG_W = 3 * BYTE_W;
  localparam int PAD_D = ADDR_W - DIR_W;
  localparam int PAD_L = ADDR_W - LONG_W;

  logic [DIR_W-1:0] dir_off;

  always_comb begin
    dir_off = dir_i + {{BYTE_W{1'b0}}, lo_i};
    case (mode_i)
      MODE_W'(MODE_DIR_X), MODE_W'(MODE_DIR_Y):
        base_o = {{PAD_D{1'b0}}, dir_off};
      MODE_W'(MODE_ABS_X), MODE_W'(MODE_ABS_Y):
        base_o = {{PAD_L{1'b0}}, dbr_i, hi_i, lo_i};
      MODE_W'(MODE_ABSL_X):
        base_o = {{PAD_L{1'b0}}, bank_i, hi_i, lo_i};
      default:
        base_o = '0;
    endcase
  end
endmodule

// File: rtl/ieag_sum_trunc.sv
module ieag_sum_trunc #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              direct_i,
  input  logic              native_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int DIR_W = 2 * BYTE_W;
  localparam int LONG_W = 3 * BYTE_W;
  localparam logic [ADDR_W-1:0] DIR_MASK  = {{(ADDR_W-DIR_W){1'b0}},  {DIR_W{1'b1}}};
  localparam logic [ADDR_W-1:0] LONG_MASK = {{(ADDR_W-LONG_W){1'b0}}, {LONG_W{1'b1}}};

  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] keep;

  always_comb begin
    raw = base_i + idx_i;
    if (direct_i)       keep = DIR_MASK;
    else if (!native_i) keep = LONG_MASK;
    else                keep = '1;
    ea_o = raw & keep;
  end
endmodule

// File: rtl/ieag_top.sv
module ieag_top
  import ieag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [MODE_W-1:0]   mode,
  input  logic                native,
  input  logic [BYTE_W-1:0]   opnd_lo,
  input  logic [BYTE_W-1:0]   opnd_hi,
  input  logic [BYTE_W-1:0]   opnd_bank,
  input  logic [2*BYTE_W-1:0] dir_reg,
  input  logic [BYTE_W-1:0]   dbr_reg,
  input  logic [ADDR_W-1:0]   x_reg,
  input  logic [ADDR_W-1:0]   y_reg,
  output logic [ADDR_W-1:0]   ea,
  output logic                ea_valid,
  output logic                mode_err
);
  localparam int DIR_W = 2 * BYTE_W;
  localparam int LONG_W = 3 * BYTE_W;

  logic              known, direct, use_y;
  logic [ADDR_W-1:0] idx, base, ea_next;

  assign known  = mode_known(mode);
  assign direct = mode_direct(mode);
  assign use_y  = mode_uses_y(mode);

  ieag_index_sel #(.ADDR_W(ADDR_W), .NARROW_W(DIR_W)) idx_i (
    .x_i(x_reg), .y_i(y_reg), .use_y_i(use_y), .native_i(native), .idx_o(idx)
  );

  ieag_base_form #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) base_i (
    .mode_i(mode), .lo_i(opnd_lo), .hi_i(opnd_hi), .bank_i(opnd_bank),
    .dir_i(dir_reg), .dbr_i(dbr_reg), .base_o(base)
  );

  ieag_sum_trunc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) sum_i (
    .base_i(base), .idx_i(idx), .direct_i(direct), .native_i(native), .ea_o(ea_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea       <= '0;
      ea_valid <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      ea_valid <= req_valid && known;
      mode_err <= req_valid && !known;
      if (req_valid && known) ea <= ea_next;
    end
  end

  a_r2_bank_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_direct(mode)) |=> (ea[ADDR_W-1:DIR_W] == '0));

  a_r6_narrow_top: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_known(mode) && !native) |=> (ea[ADDR_W-1:LONG_W] == '0));

  a_r7_valid_has_req: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> $past(req_valid));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(ea));

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mode_known(mode)) |=> (mode_err && !ea_valid && $stable(ea)));

  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (ea == '0 && !ea_valid && !mode_err));

endmodule

// File: tb/ieag_top_tb_top.sv
module ieag_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  mode;
  logic        native;
  logic [7:0]  opnd_lo, opnd_hi, opnd_bank, dbr_reg;
  logic [15:0] dir_reg;
  logic [31:0] x_reg, y_reg;
  logic [31:0] ea;
  logic        ea_valid, mode_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] last_ea = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ieag_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .native(native),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .opnd_bank(opnd_bank),
    .dir_reg(dir_reg), .dbr_reg(dbr_reg), .x_reg(x_reg), .y_reg(y_reg),
    .ea(ea), .ea_valid(ea_valid), .mode_err(mode_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pattern(input int p);
    case (p)
      0: begin opnd_lo=8'h00; opnd_hi=8'h00; opnd_bank=8'h00; dir_reg=16'h0000; dbr_reg=8'h00; x_reg=32'h0; y_reg=32'h0; end
      1: begin opnd_lo=8'h01; opnd_hi=8'h02; opnd_bank=8'h04; dir_reg=16'h0100; dbr_reg=8'h08; x_reg=32'h0000_0010; y_reg=32'h0000_0020; end
      2: begin opnd_lo=8'hFF; opnd_hi=8'hFF; opnd_bank=8'h7E; dir_reg=16'hFF80; dbr_reg=8'h12; x_reg=32'h0000_0090; y_reg=32'h0000_0001; end
      3: begin opnd_lo=8'h34; opnd_hi=8'h12; opnd_bank=8'hFF; dir_reg=16'h2000; dbr_reg=8'hFF; x_reg=32'h0001_FFFF; y_reg=32'hABCD_F000; end
      4: begin opnd_lo=8'h80; opnd_hi=8'h00; opnd_bank=8'h01; dir_reg=16'h00FF; dbr_reg=8'h00; x_reg=32'hFFFF_FFFF; y_reg=32'h8000_8000; end
      5: begin opnd_lo=8'h5A; opnd_hi=8'hA5; opnd_bank=8'hC3; dir_reg=16'hDEAD; dbr_reg=8'h3C; x_reg=32'h1234_5678; y_reg=32'h8765_4321; end
      6: begin opnd_lo=8'hFF; opnd_hi=8'hFF; opnd_bank=8'hFF; dir_reg=16'hFFFF; dbr_reg=8'hFF; x_reg=32'hFFFF_0001; y_reg=32'h00FF_0001; end
      default: begin opnd_lo=8'h10; opnd_hi=8'h20; opnd_bank=8'h30; dir_reg=16'h4000; dbr_reg=8'h50; x_reg=32'h0100_0000; y_reg=32'h0200_0000; end
    endcase
  endtask

  function automatic logic [31:0] expect_ea(input int m, input bit nat);
    longint unsigned idx, base, sum;
    idx = (m == 1 || m == 3) ? longint'(y_reg) : longint'(x_reg);
    if (m <= 1) begin
      sum = (longint'(dir_reg) + longint'(opnd_lo) + idx) & 64'hFFFF;
      return sum[31:0];
    end
    if (!nat) idx = idx & 64'hFFFF;
    if (m == 4) base = {40'h0, opnd_bank, opnd_hi, opnd_lo};
    else        base = {40'h0, dbr_reg, opnd_hi, opnd_lo};
    sum = base + idx;
    sum = nat ? (sum & 64'hFFFF_FFFF) : (sum & 64'hFF_FFFF);
    return sum[31:0];
  endfunction

  task automatic run_req(input int m, input bit nat, input int p);
    logic [31:0] exp;
    @(negedge clk);
    load_pattern(p);
    mode = m[2:0];
    native = nat;
    req_valid = 1'b1;
    exp = (m <= 4) ? expect_ea(m, nat) : last_ea;
    @(negedge clk);
    req_valid = 1'b0;
    if (m <= 1)      check("R1/R2 direct ea", ea, exp);
    else if (m <= 3) check(nat ? "R3/R5 absolute ea" : "R3/R6 absolute ea", ea, exp);
    else if (m == 4) check(nat ? "R4/R5 long ea" : "R4/R6 long ea", ea, exp);
    else             check("R9 ea unchanged on bad mode", ea, exp);
    check("R7/R9 valid pulse", {31'b0, ea_valid}, {31'b0, m <= 4});
    check("R9 error pulse", {31'b0, mode_err}, {31'b0, m > 4});
    last_ea = exp;
    load_pattern((p + 3) % 8);
    @(negedge clk);
    check("R7 valid one cycle", {31'b0, ea_valid}, 32'h0);
    check("R9 error one cycle", {31'b0, mode_err}, 32'h0);
    check("R8 ea held", ea, last_ea);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; mode = '0; native = 1'b0;
    load_pattern(5);
    repeat (3) @(negedge clk);
    check("R10 reset ea", ea, 32'h0);
    check("R10 reset valid", {31'b0, ea_valid}, 32'h0);
    check("R10 reset err", {31'b0, mode_err}, 32'h0);
    rst = 1'b0;
    for (int nat = 0; nat < 2; nat++)
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 8; p++)
          run_req(m, nat[0], p);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset ea after use", ea, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule